// File: doc/BRIEF.md
# Segmented Serial Shift Register

This block is a 64-stage serial shift register built from four 16-stage segments. A bidirectional tap sits at the end of each of the first three segments. Each tap is modelled as a tap-out value, a tap-in value and an output-enable. The last stage drives a three-state output, modelled as a value plus an enable. New data enters the first stage from a serial input on every rising clock edge.

The write-enable input selects one of two modes. In the `MODE_CHAIN` mode (write-enable low), the end of each segment feeds the start of the next one. The four segments then form one continuous 64-stage delay line, and all outputs are enabled. In the `MODE_LOAD` mode (write-enable high), every output-enable drops and the taps act as inputs. Each tap-in value is captured into the first stage of the following segment, so all four segments shift in parallel and the full register fills in 16 clocks.

The mode is decoded directly from write-enable, and the block has no other state sequence. Both transitions, `MODE_CHAIN` to `MODE_LOAD` and back, happen whenever write-enable changes. The decoded mode applies at the next rising edge. The logic is static, so with the clock stopped the contents are held. A synchronous active-low reset clears all stages.

Top module: `seg_shift_reg`

## Requirements
- R1: A clock edge with `rst_n` low clears all 64 stages, so `tap_out` and `last_out` read 0 afterwards.
- R2: On every rising edge with `rst_n` high, `ser_in` is captured into stage 1, whatever the level of `wr_en`.
- R3: With `wr_en` low, stage 16 feeds stage 17, 32 feeds 33 and 48 feeds 49, so a bit driven on `ser_in` appears on `last_out` 63 edges after the edge that captured it (64 clocks of delay in total).
- R4: With `wr_en` low, `tap_in` has no effect on any stage.
- R5: With `wr_en` high, each edge captures `tap_in[0]` into stage 17, `tap_in[1]` into stage 33 and `tap_in[2]` into stage 49, while every other stage takes the value of its predecessor.
- R6: Sixteen edges with `wr_en` high fill all 64 stages. A following run of 64 edges with `wr_en` low emits the loaded values on `last_out` in this order: first the `tap_in[2]` stream, then the `tap_in[1]` stream, then the `tap_in[0]` stream, then the `ser_in` stream, each in capture order.
- R7: `tap_out[k]` always equals stage 16·(k+1) and `last_out` always equals stage 64, in both modes.
- R8: `tap_oe` (all bits) and `last_oe` are 0 whenever `wr_en` is 1 and are 1 whenever `wr_en` is 0, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low clear of all stages |
| wr_en | input | 1 | High selects parallel segment load and disables outputs |
| ser_in | input | 1 | Serial data into stage 1 |
| tap_in | input | 3 | Tap input values, bit k feeding stage 16·(k+1)+1 in load mode |
| tap_out | output | 3 | Tap output values, bit k showing stage 16·(k+1) |
| tap_oe | output | 3 | Tap output enables, active high |
| last_out | output | 1 | Value of stage 64 |
| last_oe | output | 1 | Enable of the stage-64 three-state output, active high |

## Verification
Some properties are checked on every cycle. In each mode, the first stage of every segment must take the value selected by that mode: the previous segment's tail or the tap input. Stage 1 must always take `ser_in`. Within a segment, each stage must hand its value on by one position. The output enables must be off whenever write-enable is high. Other behaviours can only be shown by the bench's scenarios against its behavioural model: the 16-clock load followed by an ordered 64-bit drain, the exact 64-clock delay of a serial stream, the fact that tap inputs are ignored in chain mode, and clearing by reset.

// File: rtl/seg_shift_pkg.sv
package seg_shift_pkg;
    typedef enum logic {
        MODE_CHAIN = 1'b0,
        MODE_LOAD  = 1'b1
    } mode_e;
endpackage

// File: rtl/seg_mode_ctrl.sv
module seg_mode_ctrl
    import seg_shift_pkg::*;
#(
    parameter int NTAP = 3
) (
    input  logic            wr_en,
    output mode_e           mode,
    output logic [NTAP-1:0] tap_oe,
    output logic            last_oe
);
    // mode decode
    always_comb begin
        mode = wr_en ? MODE_LOAD : MODE_CHAIN;
    end

    // output enables follow the decoded mode
    always_comb begin
        unique case (mode)
            MODE_LOAD: begin
                tap_oe  = '0;
                last_oe = 1'b0;
            end
            MODE_CHAIN: begin
                tap_oe  = '1;
                last_oe = 1'b1;
            end
            default: begin
                tap_oe  = '0;
                last_oe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/seg_link.sv
module seg_link
    import seg_shift_pkg::*;
(
    input  mode_e mode,
    input  logic  prev_tail,
    input  logic  tap_val,
    output logic  seg_in
);
    always_comb begin
        unique case (mode)
            MODE_LOAD:  seg_in = tap_val;
            MODE_CHAIN: seg_in = prev_tail;
            default:    seg_in = prev_tail;
        endcase
    end
endmodule

// File: rtl/seg_stage.sv
module seg_stage #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic head,
    output logic tail
);
    logic [LEN-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (LEN == 1) begin
            bits_q <= d_in;
        end else begin
            bits_q <= {bits_q[LEN-2:0], d_in};
        end
    end

    assign head = bits_q[0];
    assign tail = bits_q[LEN-1];

    // R2 / R3 / R5: the head takes whatever the segment input offered
    a_r2_head_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> head == $past(d_in));

    generate
        if (LEN > 1) begin : g_inner
            // R3: values move one stage per edge inside the segment
            a_r3_inner_shift: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> bits_q[1] == $past(bits_q[0]));
        end
    endgenerate
endmodule

// File: rtl/seg_shift_reg.sv
module seg_shift_reg
    import seg_shift_pkg::*;
#(
    parameter int SEG_LEN = 16,
    parameter int NUM_SEG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               ser_in,
    input  logic [NUM_SEG-2:0] tap_in,
    output logic [NUM_SEG-2:0] tap_out,
    output logic [NUM_SEG-2:0] tap_oe,
    output logic               last_out,
    output logic               last_oe
);
    localparam int NTAP = NUM_SEG - 1;

    mode_e              mode;
    logic [NUM_SEG-1:0] seg_d;
    logic [NUM_SEG-1:0] seg_head;
    logic [NUM_SEG-1:0] seg_tail;

    seg_mode_ctrl #(.NTAP(NTAP)) u_ctrl (
        .wr_en   (wr_en),
        .mode    (mode),
        .tap_oe  (tap_oe),
        .last_oe (last_oe)
    );

    assign seg_d[0] = ser_in;

    genvar k;
    generate
        for (k = 0; k < NUM_SEG; k++) begin : g_seg
            if (k > 0) begin : g_link
                seg_link u_link (
                    .mode      (mode),
                    .prev_tail (seg_tail[k-1]),
                    .tap_val   (tap_in[k-1]),
                    .seg_in    (seg_d[k])
                );

                // R5: load mode takes the tap pin into the segment head
                a_r5_load_tap: assert property (@(posedge clk) disable iff (!rst_n)
                    wr_en |=> seg_head[k] == $past(tap_in[k-1]));
                // R3 / R4: chain mode links the previous tail and ignores the tap pin
                a_r3_chain_link: assert property (@(posedge clk) disable iff (!rst_n)
                    !wr_en |=> seg_head[k] == $past(seg_tail[k-1]));
            end
            seg_stage #(.LEN(SEG_LEN)) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .d_in  (seg_d[k]),
                .head  (seg_head[k]),
                .tail  (seg_tail[k])
            );
        end
    endgenerate

    assign tap_out  = seg_tail[NUM_SEG-2:0];
    assign last_out = seg_tail[NUM_SEG-1];

    // R8: nothing drives while write-enable is high
    a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !last_oe && tap_oe == '0);
    // R1: a clear leaves every segment tail at zero
    a_r1_clear: assert property (@(posedge clk)
        !rst_n |=> seg_tail == '0);
endmodule

// File: tb/seg_shift_reg_test.sv
module seg_shift_reg_test;
    localparam int SL = 16;
    localparam int NS = 4;
    localparam int TOT = SL * NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          ser_in = 1'b0;
    logic [NS-2:0] tap_in = '0;
    logic [NS-2:0] tap_out;
    logic [NS-2:0] tap_oe;
    logic          last_out;
    logic          last_oe;

    int tests = 0;
    int fails = 0;
    logic model [1:TOT];

    always #5 clk = ~clk;

    seg_shift_reg #(.SEG_LEN(SL), .NUM_SEG(NS)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ser_in(ser_in),
        .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe),
        .last_out(last_out), .last_oe(last_oe)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_taps(input string req);
        logic [NS-2:0] et;
        for (int k = 0; k < NS - 1; k++) et[k] = model[SL * (k + 1)];
        chk(req, 64'(tap_out), 64'(et));
        chk(req, 64'(last_out), 64'(model[TOT]));
    endtask

    // drive at negedge, advance model at posedge, compare at next negedge
    task automatic step(input logic rn, input logic we, input logic si, input logic [NS-2:0] ti);
        logic nxt [1:TOT];
        rst_n = rn; wr_en = we; ser_in = si; tap_in = ti;
        #1;
        chk("R8 oe", {62'd0, tap_oe == {(NS-1){!we}}, last_oe}, {62'd0, 1'b1, !we});
        @(posedge clk);
        for (int i = 1; i <= TOT; i++) begin
            if (!rn) nxt[i] = 1'b0;
            else if (i == 1) nxt[i] = si;
            else if (we && ((i - 1) % SL == 0)) nxt[i] = ti[(i - 1) / SL - 1];
            else nxt[i] = model[i - 1];
        end
        for (int i = 1; i <= TOT; i++) model[i] = nxt[i];
        @(negedge clk);
        compare_taps("R2,R5,R7 model");
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        logic exp_seq [$];
        logic strm [$];
        logic s0 [$], s1 [$], s2 [$], s3 [$];
        logic b;
        for (int i = 1; i <= TOT; i++) model[i] = 1'b0;
        @(negedge clk);

        // R1: reset clears
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, '1);
        chk("R1 reset taps", 64'(tap_out), 64'd0);
        chk("R1 reset last", 64'(last_out), 64'd0);

        // R5 / R6: parallel load in 16 clocks
        for (int i = 0; i < SL; i++) begin
            logic si; logic [NS-2:0] ti;
            si = 1'($urandom); ti = (NS-1)'($urandom);
            s0.push_back(si); s1.push_back(ti[0]); s2.push_back(ti[1]); s3.push_back(ti[2]);
            step(1'b1, 1'b1, si, ti);
        end
        foreach (s3[i]) exp_seq.push_back(s3[i]);
        foreach (s2[i]) exp_seq.push_back(s2[i]);
        foreach (s1[i]) exp_seq.push_back(s1[i]);
        foreach (s0[i]) exp_seq.push_back(s0[i]);

        // R6 drain in order, R4 tap_in toggling must be ignored
        for (int i = 0; i < TOT; i++) begin
            b = exp_seq.pop_front();
            chk("R6 drain order", 64'(last_out), 64'(b));
            step(1'b1, 1'b0, 1'b0, (NS-1)'($urandom));
        end
        chk("R4 drained register empty", 64'(last_out), 64'd0);

        // R3: serial stream delayed by 64 clocks
        for (int i = 0; i < 150; i++) begin
            logic si;
            si = 1'($urandom);
            strm.push_back(si);
            step(1'b1, 1'b0, si, (NS-1)'($urandom));
            if (strm.size() == TOT) begin
                b = strm.pop_front();
                chk("R3 64-clock delay", 64'(last_out), 64'(b));
            end
        end

        // mixed mode toggling, R2 shift regardless of wr_en
        for (int i = 0; i < 300; i++)
            step(1'b1, 1'($urandom), 1'($urandom), (NS-1)'($urandom));

        // R1: clear in mid-run
        step(1'b0, 1'b1, 1'b1, '1);
        chk("R1 mid-run clear taps", 64'(tap_out), 64'd0);
        chk("R1 mid-run clear last", 64'(last_out), 64'd0);
        step(1'b1, 1'b0, 1'b0, '0);

        report();
    end
endmodule